// File: doc/BRIEF.md
# Simple Floating-Point Operation Unit

This block executes the inexpensive single-precision operations of a vector processing pipeline. It handles only the operations that need no adder tree, multiplier or normaliser. These are:

- magnitude (absolute value)
- raw copy
- greater-than and equality tests that produce the floats 1.0 or 0.0
- a select steered by a flags word
- sign transfer
- the bit-trick seed used to start an inverse-square-root iteration

Each cycle the issuing logic may present one opcode, two 32-bit operands A and B, and the current flags word, qualified by `issue_valid`. Every accepted operation returns its 32-bit result after a fixed latency of two clock edges, with a one-cycle `res_valid` pulse. A new operation can be issued every cycle.

Top module: `fp_lite_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, with nothing issued, `res_valid` is 0 and `res_data` is 0x00000000.
- R2: An operation with a defined code is sampled at rising edge N while `issue_valid` is 1. Its result appears on `res_data` with `res_valid` high for exactly one cycle, after edge N+1. Operations issued on consecutive cycles produce results on consecutive cycles.
- R3: Code 0 (no operation) and the unused codes 1, 2, 3, 5, 6, 7, 8 and 9 produce no result: `res_valid` stays 0 and `res_data` keeps its previous value.
- R4: Code 4 (magnitude) returns A with bit 31 cleared.
- R5: Code 10 (greater-than) returns 0x3F800000 when A > B as single-precision values and 0x00000000 otherwise. Zeros of either sign compare as equal, and a NaN in either operand yields 0x00000000.
- R6: Code 11 (equality) returns 0x3F800000 when A equals B as single-precision values and 0x00000000 otherwise. +0 equals -0, and a NaN in either operand yields 0x00000000, even when the bit patterns are identical.
- R7: Code 12 (copy) returns the raw bits of A.
- R8: Code 13 (select) returns A when the flags word is nonzero and B when it is zero.
- R9: Code 14 (sign transfer) returns A with bit 31 inverted when B is strictly negative, and A unchanged otherwise. Negative zero and NaN values of B do not count as negative.
- R10: Code 15 (root seed) returns 0x5F3759DF minus A logically shifted right by one bit, modulo 2^32.
- R11: When `issue_valid` is 0 at an edge, that edge produces no result, whatever the opcode and operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Qualifies the opcode and operands in this cycle |
| issue_op | input | 4 | Operation code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| flags_in | input | 32 | Flags word used by select |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 32 | Result word, held between results |

## Verification
A wrong opcode decode or a corrupted operand register shows up as a wrong `res_data` word in the very cycle that `res_valid` pulses, two edges after issue. Each table entry is therefore checked at that exact cycle. A lost or duplicated valid bit in either pipeline stage shows up within one cycle as a missing pulse or as a pulse that lasts two cycles. The bench checks the cycle after every result for this. Stale state in the result register is exposed by issuing an ignored code right after a known result and checking that the word is still held.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  localparam int FPL_W    = 32;
  localparam int FPL_OP_W = 4;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = FPL_W - EXP_W - 1;
  localparam int SIGN_BIT = FPL_W - 1;

  localparam logic [FPL_W-1:0] FP_ONE     = 32'h3F80_0000;
  localparam logic [FPL_W-1:0] FP_ZERO    = '0;
  localparam logic [FPL_W-1:0] SEED_MAGIC = 32'h5F37_59DF;

  typedef enum logic [FPL_OP_W-1:0] {
    OPC_IDLE   = 4'd0,
    OPC_MAG    = 4'd4,
    OPC_GT     = 4'd10,
    OPC_EQ     = 4'd11,
    OPC_PASS   = 4'd12,
    OPC_PICK   = 4'd13,
    OPC_SGNXFR = 4'd14,
    OPC_RSEED  = 4'd15
  } fpl_op_e;

  function automatic logic fpl_op_legal(input logic [FPL_OP_W-1:0] op);
    case (op)
      OPC_MAG, OPC_GT, OPC_EQ, OPC_PASS,
      OPC_PICK, OPC_SGNXFR, OPC_RSEED: fpl_op_legal = 1'b1;
      default:                         fpl_op_legal = 1'b0;
    endcase
  endfunction

  function automatic logic fpl_is_nan(input logic [FPL_W-1:0] v);
    fpl_is_nan = (&v[SIGN_BIT-1 -: EXP_W]) && (|v[MAN_W-1:0]);
  endfunction

  function automatic logic fpl_is_zero(input logic [FPL_W-1:0] v);
    fpl_is_zero = ~|v[SIGN_BIT-1:0];
  endfunction

  // ordered greater-than on sign-magnitude values
  function automatic logic fpl_gt(input logic [FPL_W-1:0] a,
                                  input logic [FPL_W-1:0] b);
    logic [FPL_W-2:0] ma, mb;
    ma = a[SIGN_BIT-1:0];
    mb = b[SIGN_BIT-1:0];
    if (fpl_is_nan(a) || fpl_is_nan(b))           fpl_gt = 1'b0;
    else if (fpl_is_zero(a) && fpl_is_zero(b))    fpl_gt = 1'b0;
    else if (a[SIGN_BIT] != b[SIGN_BIT])          fpl_gt = b[SIGN_BIT];
    else if (!a[SIGN_BIT])                        fpl_gt = ma > mb;
    else                                          fpl_gt = ma < mb;
  endfunction

  function automatic logic fpl_eq(input logic [FPL_W-1:0] a,
                                  input logic [FPL_W-1:0] b);
    if (fpl_is_nan(a) || fpl_is_nan(b))           fpl_eq = 1'b0;
    else if (fpl_is_zero(a) && fpl_is_zero(b))    fpl_eq = 1'b1;
    else                                          fpl_eq = (a == b);
  endfunction

  function automatic logic fpl_strict_neg(input logic [FPL_W-1:0] v);
    fpl_strict_neg = v[SIGN_BIT] && !fpl_is_zero(v) && !fpl_is_nan(v);
  endfunction

  function automatic logic [FPL_W-1:0] fpl_seed(input logic [FPL_W-1:0] a);
    fpl_seed = SEED_MAGIC - (a >> 1);
  endfunction

  function automatic logic [FPL_W-1:0] fpl_bool(input logic c);
    fpl_bool = c ? FP_ONE : FP_ZERO;
  endfunction

endpackage

// File: rtl/fpl_issue_stage.sv
module fpl_issue_stage
  import fpl_pkg::*;
#(
  parameter int W   = FPL_W,
  parameter int OPW = FPL_OP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_valid,
  input  logic [OPW-1:0] issue_op,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [W-1:0]   flags_in,
  output logic           accept,
  output logic           s1_valid,
  output logic [OPW-1:0] s1_op,
  output logic [W-1:0]   s1_a,
  output logic [W-1:0]   s1_b,
  output logic           s1_flag_set
);

  assign accept = issue_valid && fpl_op_legal(issue_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_op       <= '0;
      s1_a        <= '0;
      s1_b        <= '0;
      s1_flag_set <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_op       <= issue_op;
        s1_a        <= opnd_a;
        s1_b        <= opnd_b;
        s1_flag_set <= |flags_in;
      end
    end
  end

endmodule

// File: rtl/fpl_exec.sv
module fpl_exec
  import fpl_pkg::*;
#(
  parameter int W   = FPL_W,
  parameter int OPW = FPL_OP_W
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           flag_set,
  output logic [W-1:0]   result
);

  localparam logic [W-1:0] SIGN_MASK = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    case (op)
      OPC_MAG:    result = a & ~SIGN_MASK;
      OPC_GT:     result = fpl_bool(fpl_gt(a, b));
      OPC_EQ:     result = fpl_bool(fpl_eq(a, b));
      OPC_PASS:   result = a;
      OPC_PICK:   result = flag_set ? a : b;
      OPC_SGNXFR: result = fpl_strict_neg(b) ? (a ^ SIGN_MASK) : a;
      OPC_RSEED:  result = fpl_seed(a);
      default:    result = '0;
    endcase
  end

endmodule

// File: rtl/fpl_result_stage.sv
module fpl_result_stage
  import fpl_pkg::*;
#(
  parameter int W   = FPL_W,
  parameter int OPW = FPL_OP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s1_valid,
  input  logic [OPW-1:0] s1_op,
  input  logic [W-1:0]   exec_result,
  output logic           res_valid,
  output logic [OPW-1:0] s2_op,
  output logic [W-1:0]   res_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      s2_op     <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        s2_op    <= s1_op;
        res_data <= exec_result;
      end
    end
  end

endmodule

// File: rtl/fp_lite_unit.sv
module fp_lite_unit
  import fpl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_valid,
  input  logic [3:0]  issue_op,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [31:0] flags_in,
  output logic        res_valid,
  output logic [31:0] res_data
);

  localparam int W   = FPL_W;
  localparam int OPW = FPL_OP_W;

  logic           accept;
  logic           s1_valid;
  logic [OPW-1:0] s1_op;
  logic [W-1:0]   s1_a, s1_b;
  logic           s1_flag_set;
  logic [W-1:0]   exec_result;
  logic [OPW-1:0] s2_op;

  fpl_issue_stage #(.W(W), .OPW(OPW)) u_issue (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
    .accept(accept), .s1_valid(s1_valid), .s1_op(s1_op),
    .s1_a(s1_a), .s1_b(s1_b), .s1_flag_set(s1_flag_set)
  );

  fpl_exec #(.W(W), .OPW(OPW)) u_exec (
    .op(s1_op), .a(s1_a), .b(s1_b), .flag_set(s1_flag_set),
    .result(exec_result)
  );

  fpl_result_stage #(.W(W), .OPW(OPW)) u_result (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_op(s1_op),
    .exec_result(exec_result), .res_valid(res_valid), .s2_op(s2_op),
    .res_data(res_data)
  );

  // R2: an accepted issue yields a result two edges later
  a_r2_result_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 res_valid);

  // R3 / R11: an issue that is not accepted yields no result
  a_r3_ignored_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ##1 !res_valid);

  // R3: result word is held when no result is produced
  a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(res_data));

  // R4: magnitude never has its sign bit set
  a_r4_mag_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && s2_op == OPC_MAG) |-> !res_data[W-1]);

  // R5 / R6: comparisons produce only 1.0 or 0.0
  a_r5_cmp_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (s2_op == OPC_GT || s2_op == OPC_EQ)) |->
      (res_data == FP_ONE || res_data == FP_ZERO));

  // R7: copy reproduces the staged operand
  a_r7_copy_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op == OPC_PASS) |=> res_data == $past(s1_a));

  // R9: sign transfer changes nothing but the sign bit
  a_r9_sign_only: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op == OPC_SGNXFR) |=> res_data[W-2:0] == $past(s1_a[W-2:0]));

endmodule

// File: tb/test_fp_lite_unit.sv
module test_fp_lite_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [3:0]  issue_op = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, flags_in = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fp_lite_unit i_fp_lite_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
    .res_valid(res_valid), .res_data(res_data)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] f;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  32'hC049_0FDB, 32'h0, 32'h0, 32'h4049_0FDB, 8'd4},  // R4
    '{4'd4,  32'h8000_0000, 32'h0, 32'h0, 32'h0000_0000, 8'd4},  // R4
    '{4'd10, 32'h3F80_0000, 32'h4000_0000, 32'h0, 32'h0000_0000, 8'd5},  // R5
    '{4'd10, 32'h4000_0000, 32'h3F80_0000, 32'h0, 32'h3F80_0000, 8'd5},  // R5
    '{4'd10, 32'hBF80_0000, 32'hC000_0000, 32'h0, 32'h3F80_0000, 8'd5},  // R5
    '{4'd10, 32'h0000_0000, 32'h8000_0000, 32'h0, 32'h0000_0000, 8'd5},  // R5
    '{4'd10, 32'h7FC0_0000, 32'h0000_0000, 32'h0, 32'h0000_0000, 8'd5},  // R5
    '{4'd10, 32'h3F80_0000, 32'hBF80_0000, 32'h0, 32'h3F80_0000, 8'd5},  // R5
    '{4'd11, 32'h8000_0000, 32'h0000_0000, 32'h0, 32'h3F80_0000, 8'd6},  // R6
    '{4'd11, 32'h7FC0_0000, 32'h7FC0_0000, 32'h0, 32'h0000_0000, 8'd6},  // R6
    '{4'd11, 32'h1234_5678, 32'h1234_5678, 32'h0, 32'h3F80_0000, 8'd6},  // R6
    '{4'd11, 32'h3F80_0000, 32'h3F80_0001, 32'h0, 32'h0000_0000, 8'd6},  // R6
    '{4'd12, 32'hDEAD_BEEF, 32'h0, 32'h0, 32'hDEAD_BEEF, 8'd7},  // R7
    '{4'd13, 32'h1111_1111, 32'h2222_2222, 32'h1, 32'h1111_1111, 8'd8},  // R8
    '{4'd13, 32'h1111_1111, 32'h2222_2222, 32'h0, 32'h2222_2222, 8'd8},  // R8
    '{4'd13, 32'h1111_1111, 32'h2222_2222, 32'h8000_0000, 32'h1111_1111, 8'd8},  // R8
    '{4'd14, 32'h3F80_0000, 32'hBF80_0000, 32'h0, 32'hBF80_0000, 8'd9},  // R9
    '{4'd14, 32'h3F80_0000, 32'h8000_0000, 32'h0, 32'h3F80_0000, 8'd9},  // R9
    '{4'd14, 32'hBF80_0000, 32'h4000_0000, 32'h0, 32'hBF80_0000, 8'd9},  // R9
    '{4'd14, 32'h3F80_0000, 32'hFFC0_0000, 32'h0, 32'h3F80_0000, 8'd9},  // R9
    '{4'd15, 32'h3F80_0000, 32'h0, 32'h0, 32'h3F77_59DF, 8'd10},  // R10
    '{4'd15, 32'h0000_0000, 32'h0, 32'h0, 32'h5F37_59DF, 8'd10},  // R10
    '{4'd15, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hDF37_59E0, 8'd10}   // R10
  };

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] f);
    issue_valid = v; issue_op = op; opnd_a = a; opnd_b = b; flags_in = f;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 valid in reset", {31'b0, res_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {31'b0, res_valid}, 32'd0);
    check("R1 data after reset", res_data, 32'd0);

    // table walk: one issue, result checked two edges later, then pulse end
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].f);
      @(negedge clk);
      drive(1'b0, 4'd0, '0, '0, '0);
      check("R2 no early valid", {31'b0, res_valid}, 32'd0);
      @(negedge clk);
      check("R2 valid at latency", {31'b0, res_valid}, 32'd1);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), res_data, VECS[i].exp);
      @(negedge clk);
      check("R2 single pulse", {31'b0, res_valid}, 32'd0);
    end

    // R2: back-to-back throughput
    drive(1'b1, 4'd12, 32'hA5A5_0001, '0, '0); @(negedge clk);
    drive(1'b1, 4'd4,  32'hFFFF_0002, '0, '0); @(negedge clk);
    drive(1'b1, 4'd15, 32'h0000_0002, '0, '0);
    check("R2 burst first", res_data, 32'hA5A5_0001);
    check("R2 burst valid", {31'b0, res_valid}, 32'd1);
    @(negedge clk);
    drive(1'b0, 4'd0, '0, '0, '0);
    check("R2 burst second", res_data, 32'h7FFF_0002);
    check("R2 burst valid", {31'b0, res_valid}, 32'd1);
    @(negedge clk);
    check("R2 burst third", res_data, 32'h5F37_59DE);
    @(negedge clk);
    check("R2 burst end", {31'b0, res_valid}, 32'd0);
    held = res_data;

    // R3: no-op and every unused code produce nothing and hold data
    for (int c = 0; c < 10; c++) begin
      if (c == 4) continue;
      drive(1'b1, c[3:0], 32'h1357_9BDF, 32'h2468_ACE0, 32'h1);
      @(negedge clk);
      drive(1'b0, 4'd0, '0, '0, '0);
      @(negedge clk);
      check($sformatf("R3 code %0d valid", c), {31'b0, res_valid}, 32'd0);
      check($sformatf("R3 code %0d data held", c), res_data, held);
    end

    // R11: legal opcode without issue_valid is ignored
    drive(1'b0, 4'd12, 32'hCAFE_F00D, '0, '0);
    @(negedge clk);
    drive(1'b0, 4'd0, '0, '0, '0);
    @(negedge clk);
    check("R11 valid", {31'b0, res_valid}, 32'd0);
    check("R11 data held", res_data, held);

    finish_run();
  end

endmodule